// File: doc/BRIEF.md
# Bipolar Substitution Decoder with Code Violation Flagging

This block sits after the data slicer of a coaxial line receiver. It takes the two received rails, `rx_pos` and `rx_neg`, one symbol per cycle of the recovered clock. It removes the zero-substitution patterns that the far-end encoder put into the line, and it rebuilds the NRZ bit stream. Two zero-substitution codes are supported. The three-zero code is used on the 44.7 and 51.8 Mbit/s rates, and the four-zero code on the 34.4 Mbit/s rate. `mode_hdb3` selects between them.

With decoding enabled, the positive-data output carries NRZ data. The negative-data output then becomes a violation indicator: it goes high for one clock, in the same cycle as the NRZ bit that broke a line-coding rule. With decoding disabled, both outputs carry the raw rails so that an external framer can decode them itself. A control input inverts the recovered clock that is handed on to that framer.

Rail encoding, used throughout:

| `rx_pos` | `rx_neg` | Symbol |
|---|---|---|
| 1 | 0 | positive pulse |
| 0 | 1 | negative pulse |
| 0 | 0 | zero |
| 1 | 1 | a pulse on both rails |

Pulse types:
- A **V** (violation pulse) is a single-rail pulse with the same polarity as the previous single-rail pulse.
- Every other single-rail pulse is a **B**.
- The first pulse after reset is always a B.

Top module: `ami_subst_decoder`

## Requirements
- R1: With `dec_en`=1, `rpos_o` carries the NRZ data (1 for any pulse, 0 for a zero). The bit for a symbol sampled at clock edge n appears after edge n+2 in the three-zero code (`mode_hdb3`=0) and after edge n+3 in the four-zero code (`mode_hdb3`=1). That is a latency of 3 or 4 edges.
- R2: In the three-zero code, a V whose preceding symbol is a zero marks a substitution. The V and the symbol two places before it are output as 0, giving 00V → 000 and B0V → 000.
- R3: In the four-zero code, a V whose two preceding symbols are zeros marks a substitution. The V and the symbol three places before it are output as 0, giving 000V → 0000 and B00V → 0000.
- R4: `rneg_o` is 1 for every zero that extends a run of zeros beyond 2 symbols (three-zero code) or beyond 3 symbols (four-zero code).
- R5: `rneg_o` is 1 on a V that directly follows another pulse in either code. In the four-zero code it is also 1 on a V preceded by exactly one zero and then a pulse. Such a V is not substituted and is output as 1.
- R6: `rneg_o` is 1 on a V when an even number (including zero) of B pulses came since the previous V. No parity check is made on the first V after reset.
- R7: A symbol with both rails high gives `rneg_o`=1 and `rpos_o`=1 for that bit. It leaves the polarity history unchanged.
- R8: With `dec_en`=0, `rpos_o` and `rneg_o` equal `rx_pos` and `rx_neg`, delayed by the same latency as in R1, with no substitution removed.
- R9: `rclk_o` equals `clk` when `rclk_inv`=0 and its inverse when `rclk_inv`=1.
- R10: A synchronous reset (`rst_n`=0 at a clock edge) drives both data outputs to 0. It clears all history, so the first pulse after reset is treated as a B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one symbol per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_en | input | 1 | 1 = decode, 0 = pass raw rails through |
| mode_hdb3 | input | 1 | 0 = three-zero substitution code, 1 = four-zero code |
| rclk_inv | input | 1 | Inverts the forwarded clock |
| rx_pos | input | 1 | Received positive rail |
| rx_neg | input | 1 | Received negative rail |
| rpos_o | output | 1 | NRZ data (decode) or delayed positive rail (bypass) |
| rneg_o | output | 1 | Violation pulse (decode) or delayed negative rail (bypass) |
| rclk_o | output | 1 | Forwarded clock with selectable polarity |

## Verification
The hardest situation to reach from the ports is the parity rule. It depends on a B count and a last-polarity register that are never visible, and a wrong count only shows up at the next V. The stimulus therefore builds each parity case explicitly:
- legal substitutions preceded by odd B counts, which must stay silent;
- a V preceded by exactly two B pulses;
- two back-to-back V pulses.

Each of these is laid out symbol by symbol after a reset, so the hidden counter starts from a known value. Zero-spacing errors of both shapes, and a both-rails symbol placed between pulses, test that these events neither lose nor corrupt the polarity history seen by later pulses.

// File: rtl/b3hd_pkg.sv
// Package b3hd_pkg
// Shared constants and helpers for the bipolar substitution decoder.
// Assumes one symbol per clock and at most two rails per symbol.
package b3hd_pkg;

    localparam int WIN_SHORT_D = 3;  // window length, three-zero code
    localparam int WIN_LONG_D  = 4;  // window length, four-zero code
    localparam int ZLIM_SHORT_D = 2; // longest legal zero run, three-zero code
    localparam int ZLIM_LONG_D  = 3; // longest legal zero run, four-zero code
    localparam int ZRUN_W_D     = 3; // width of the zero-run counter

    // True when either rail carries a pulse.
    function automatic logic rail_any(input logic p, input logic n);
        return p | n;
    endfunction

endpackage

// File: rtl/lc_symbol_judge.sv
// Module lc_symbol_judge
// Classifies each incoming symbol as zero, B, V or dual-rail. It keeps the
// polarity, B-parity and zero-run history, and decides whether the symbol
// closes a legal substitution or breaks a coding rule.
// Assumes hist0_i/hist1_i are the raw pulse flags of the previous one and
// two symbols, and that the mode is static while traffic flows.
module lc_symbol_judge
    import b3hd_pkg::*;
#(
    parameter int ZLIM_SHORT = ZLIM_SHORT_D,
    parameter int ZLIM_LONG  = ZLIM_LONG_D,
    parameter int ZRUN_W     = ZRUN_W_D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic hdb3_i,
    input  logic hist0_i,
    input  logic hist1_i,
    output logic one_o,
    output logic viol_o,
    output logic kill_new_o,
    output logic kill_b_o
);

    localparam logic [ZRUN_W-1:0] ZSAT     = '1;
    localparam logic [ZRUN_W-1:0] LIM_S    = ZRUN_W'(ZLIM_SHORT);
    localparam logic [ZRUN_W-1:0] LIM_L    = ZRUN_W'(ZLIM_LONG);

    logic              last_pol;
    logic              seen_pulse;
    logic              seen_v;
    logic              b_odd;
    logic [ZRUN_W-1:0] zrun;

    logic pulse, dual, single, is_v, is_b;
    logic short_gap, par_bad, excess;
    logic [ZRUN_W-1:0] zlim, zrun_nx;

    // Symbol classification and rule checks for the current symbol.
    always_comb begin
        pulse     = rail_any(pos_i, neg_i);
        dual      = pos_i & neg_i;
        single    = pulse & ~dual;
        is_v      = single & seen_pulse & (pos_i == last_pol);
        is_b      = single & ~is_v;
        zlim      = hdb3_i ? LIM_L : LIM_S;
        excess    = ~pulse & (zrun >= zlim);
        short_gap = is_v & (hist0_i | (hdb3_i & hist1_i));
        par_bad   = is_v & seen_v & ~b_odd;
        if (pulse)
            zrun_nx = '0;
        else if (zrun == ZSAT)
            zrun_nx = zrun;
        else
            zrun_nx = zrun + 1'b1;
    end

    assign one_o      = pulse;
    assign viol_o     = dual | excess | short_gap | par_bad;
    assign kill_new_o = is_v & ~short_gap;
    assign kill_b_o   = is_v & ~short_gap;

    // History update: polarity, B parity since last V, zero run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pol   <= 1'b0;
            seen_pulse <= 1'b0;
            seen_v     <= 1'b0;
            b_odd      <= 1'b0;
            zrun       <= '0;
        end else begin
            zrun <= zrun_nx;
            if (single) begin
                last_pol   <= pos_i;
                seen_pulse <= 1'b1;
            end
            if (is_v) begin
                seen_v <= 1'b1;
                b_odd  <= 1'b0;
            end else if (is_b) begin
                b_odd  <= ~b_odd;
            end
        end
    end

    // A flagged V never also gets substituted when its spacing was short.
    AST_SHORT_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i ^ neg_i) && hist0_i && kill_new_o |-> 1'b0)
        else $error("substitution accepted right after a pulse"); // R5

endmodule

// File: rtl/lc_align_pipe.sv
// Module lc_align_pipe
// Delay line that holds the raw rails, the decoded bits and the violation
// flags. It erases the substituted positions and taps the stage that matches
// the window length of the active code.
// Assumes WIN_LONG >= WIN_SHORT >= 2 and that kill requests come from the
// judge in the same cycle as the symbol that triggered them.
module lc_align_pipe
    import b3hd_pkg::*;
#(
    parameter int WIN_SHORT = WIN_SHORT_D,
    parameter int WIN_LONG  = WIN_LONG_D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic one_i,
    input  logic viol_i,
    input  logic kill_new_i,
    input  logic kill_b_i,
    input  logic hdb3_i,
    input  logic dec_en_i,
    output logic hist0_o,
    output logic hist1_o,
    output logic rpos_o,
    output logic rneg_o
);

    localparam int DEPTH = WIN_LONG;
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IW-1:0] TAP_S = IW'(WIN_SHORT - 1);
    localparam logic [IW-1:0] TAP_L = IW'(WIN_LONG - 1);

    logic [DEPTH-1:0] pos_q, neg_q, dat_q, vio_q;
    logic [DEPTH-1:0] dat_nx;
    logic [IW-1:0]    tap;

    // The stage the output reads is also the stage where a B is erased.
    assign tap = hdb3_i ? TAP_L : TAP_S;

    // Next decoded bits: shift, then erase the V and the B slot if requested.
    always_comb begin
        dat_nx = {dat_q[DEPTH-2:0], one_i & ~kill_new_i};
        if (kill_b_i)
            dat_nx[tap] = 1'b0;
    end

    // Advance every lane of the delay line by one symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            neg_q <= '0;
            dat_q <= '0;
            vio_q <= '0;
        end else begin
            pos_q <= {pos_q[DEPTH-2:0], pos_i};
            neg_q <= {neg_q[DEPTH-2:0], neg_i};
            dat_q <= dat_nx;
            vio_q <= {vio_q[DEPTH-2:0], viol_i};
        end
    end

    assign hist0_o = rail_any(pos_q[0], neg_q[0]);
    assign hist1_o = rail_any(pos_q[1], neg_q[1]);
    assign rpos_o  = dec_en_i ? dat_q[tap] : pos_q[tap];
    assign rneg_o  = dec_en_i ? vio_q[tap] : neg_q[tap];

    AST_V_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        kill_new_i |=> !dat_q[0])
        else $error("substituted V kept as one"); // R2
    AST_LONG_B_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_b_i && hdb3_i) |=> !dat_q[WIN_LONG-1])
        else $error("four-zero B slot kept"); // R3
    AST_SHORT_B_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_b_i && !hdb3_i) |=> !dat_q[WIN_SHORT-1])
        else $error("three-zero B slot kept"); // R2
    AST_DUAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && neg_i) |=> (vio_q[0] && dat_q[0]))
        else $error("dual-rail symbol not flagged"); // R7

endmodule

// File: rtl/lc_clk_pol.sv
// Module lc_clk_pol
// Forwards the recovered clock with a selectable polarity.
// Assumes inv_i changes only while the downstream logic is idle.
module lc_clk_pol (
    input  logic clk_i,
    input  logic inv_i,
    output logic clk_o
);

    // XOR inverts the clock when requested.
    assign clk_o = clk_i ^ inv_i;

endmodule

// File: rtl/ami_subst_decoder.sv
// Module ami_subst_decoder (top)
// Bipolar zero-substitution decoder for the three-zero and four-zero codes,
// with violation pulses on the negative output and a raw-rail bypass.
// Assumes one symbol per rising clk edge and a static mode during traffic.
module ami_subst_decoder
    import b3hd_pkg::*;
#(
    parameter int WIN_SHORT  = WIN_SHORT_D,
    parameter int WIN_LONG   = WIN_LONG_D,
    parameter int ZLIM_SHORT = ZLIM_SHORT_D,
    parameter int ZLIM_LONG  = ZLIM_LONG_D,
    parameter int ZRUN_W     = ZRUN_W_D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_en,
    input  logic mode_hdb3,
    input  logic rclk_inv,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic rpos_o,
    output logic rneg_o,
    output logic rclk_o
);

    logic one_w, viol_w, kill_new_w, kill_b_w, hist0_w, hist1_w;

    // Symbol classification and rule checking.
    lc_symbol_judge #(
        .ZLIM_SHORT (ZLIM_SHORT),
        .ZLIM_LONG  (ZLIM_LONG),
        .ZRUN_W     (ZRUN_W)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_i      (rx_pos),
        .neg_i      (rx_neg),
        .hdb3_i     (mode_hdb3),
        .hist0_i    (hist0_w),
        .hist1_i    (hist1_w),
        .one_o      (one_w),
        .viol_o     (viol_w),
        .kill_new_o (kill_new_w),
        .kill_b_o   (kill_b_w)
    );

    // Alignment, erasure and output selection.
    lc_align_pipe #(
        .WIN_SHORT (WIN_SHORT),
        .WIN_LONG  (WIN_LONG)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_i      (rx_pos),
        .neg_i      (rx_neg),
        .one_i      (one_w),
        .viol_i     (viol_w),
        .kill_new_i (kill_new_w),
        .kill_b_i   (kill_b_w),
        .hdb3_i     (mode_hdb3),
        .dec_en_i   (dec_en),
        .hist0_o    (hist0_w),
        .hist1_o    (hist1_w),
        .rpos_o     (rpos_o),
        .rneg_o     (rneg_o)
    );

    // Forwarded clock polarity.
    lc_clk_pol u_clkpol (
        .clk_i (clk),
        .inv_i (rclk_inv),
        .clk_o (rclk_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rpos_o && !rneg_o))
        else $error("outputs not cleared by reset"); // R10

endmodule

// File: tb/sim_ami_subst_decoder.sv
// Testbench for ami_subst_decoder: vector table walk plus directed tests.
module sim_ami_subst_decoder;

    logic clk = 1'b0;
    logic rst_n, dec_en, mode_hdb3, rclk_inv, rx_pos, rx_neg;
    logic rpos_o, rneg_o, rclk_o;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    ami_subst_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_en    (dec_en),
        .mode_hdb3 (mode_hdb3),
        .rclk_inv  (rclk_inv),
        .rx_pos    (rx_pos),
        .rx_neg    (rx_neg),
        .rpos_o    (rpos_o),
        .rneg_o    (rneg_o),
        .rclk_o    (rclk_o)
    );

    // Entry bits: {mode, pos, neg, expected nrz, expected violation}
    localparam int NV = 55;
    localparam logic [4:0] TBL [NV] = '{
        // three-zero code (mode 0), latency 3
        5'b0_10_1_0, // 0 P first pulse is B (R10)
        5'b0_01_1_0, // 1 N B
        5'b0_00_0_0, // 2
        5'b0_00_0_0, // 3
        5'b0_01_0_0, // 4 V closes 00V, first V has no parity check (R2, R6)
        5'b0_10_1_0, // 5 B
        5'b0_01_1_0, // 6 B
        5'b0_10_0_0, // 7 B of B0V erased (R2)
        5'b0_00_0_0, // 8
        5'b0_10_0_0, // 9 V of B0V, three B since last V: legal
        5'b0_01_1_0, // 10 B
        5'b0_10_1_0, // 11 B (two B: even)
        5'b0_00_0_0, // 12
        5'b0_00_0_0, // 13
        5'b0_10_0_1, // 14 V after even B count (R6)
        5'b0_10_1_1, // 15 V right after V: spacing error, kept as one (R5)
        5'b0_00_0_0, // 16
        5'b0_00_0_0, // 17
        5'b0_00_0_1, // 18 third zero (R4)
        5'b0_00_0_1, // 19 fourth zero (R4)
        5'b0_01_1_0, // 20 B
        5'b0_11_1_1, // 21 dual rail (R7)
        5'b0_10_1_0, // 22 B: polarity history untouched by 21 (R7)
        5'b0_00_0_0, // 23
        5'b0_00_0_0, // 24 trailing
        5'b0_01_1_0, // 25 trailing
        // four-zero code (mode 1), latency 4
        5'b1_10_1_0, // 0 B
        5'b1_00_0_0, // 1
        5'b1_00_0_0, // 2
        5'b1_00_0_0, // 3 third zero is legal here
        5'b1_10_0_0, // 4 V closes 000V (R3)
        5'b1_01_1_0, // 5 B
        5'b1_10_1_0, // 6 B
        5'b1_01_0_0, // 7 B of B00V erased (R3)
        5'b1_00_0_0, // 8
        5'b1_00_0_0, // 9
        5'b1_01_0_0, // 10 V of B00V, odd count
        5'b1_10_1_0, // 11 B
        5'b1_10_1_1, // 12 V right after B (R5)
        5'b1_01_1_0, // 13 B
        5'b1_00_0_0, // 14
        5'b1_01_1_1, // 15 B,0,V spacing error (R5)
        5'b1_00_0_0, // 16
        5'b1_00_0_0, // 17
        5'b1_00_0_0, // 18
        5'b1_00_0_1, // 19 fourth zero (R4)
        5'b1_10_1_0, // 20 B
        5'b1_01_1_0, // 21 B (two B: even)
        5'b1_00_0_0, // 22
        5'b1_00_0_0, // 23
        5'b1_00_0_0, // 24
        5'b1_01_0_1, // 25 V closes 000V after even B count (R6)
        5'b1_00_0_0, // 26 trailing
        5'b1_00_0_0, // 27 trailing
        5'b1_00_0_0  // 28 trailing
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one symbol at the falling edge, return just after the next rising edge.
    task automatic step(input logic p, input logic n);
        @(negedge clk);
        rst_n  = 1'b1;
        rx_pos = p;
        rx_neg = n;
        @(posedge clk);
        #2;
    endtask

    // Hold reset for two edges and check that the outputs are cleared (R10).
    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        rx_pos = 1'b0;
        rx_neg = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R10 rpos after reset", rpos_o, 1'b0);
        chk("R10 rneg after reset", rneg_o, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seg = 0;
        rst_n = 1'b0; dec_en = 1'b1; mode_hdb3 = 1'b0; rclk_inv = 1'b0;
        rx_pos = 1'b0; rx_neg = 1'b0;

        // Vector table walk (R1 to R7).
        for (int i = 0; i < NV; i++) begin
            int lat;
            int j;
            if (i == 0 || TBL[i][4] != TBL[i-1][4]) begin
                mode_hdb3 = TBL[i][4];
                do_reset();
                seg = i;
            end
            step(TBL[i][3], TBL[i][2]);
            lat = TBL[i][4] ? 4 : 3;
            j   = i - (lat - 1);
            if (j >= seg) begin
                chk($sformatf("R1 nrz entry %0d", j), rpos_o, TBL[j][1]);
                chk($sformatf("R4/5/6/7 violation entry %0d", j), rneg_o, TBL[j][0]);
            end
        end

        // R10: history is cleared. A P before reset would make the next P a V.
        mode_hdb3 = 1'b0;
        step(1'b1, 1'b0);
        do_reset();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        chk("R10 first pulse after reset is B (nrz)", rpos_o, 1'b1);
        chk("R10 first pulse after reset is B (no violation)", rneg_o, 1'b0);

        // R8: bypass passes raw rails with the three-zero latency.
        begin
            logic [1:0] bp [8] = '{2'b10, 2'b01, 2'b00, 2'b00,
                                   2'b01, 2'b11, 2'b00, 2'b00};
            dec_en = 1'b0;
            do_reset();
            for (int i = 0; i < 8; i++) begin
                step(bp[i][1], bp[i][0]);
                if (i >= 2) begin
                    chk($sformatf("R8 pos rail %0d", i - 2), rpos_o, bp[i-2][1]);
                    chk($sformatf("R8 neg rail %0d", i - 2), rneg_o, bp[i-2][0]);
                end
            end
            dec_en = 1'b1;
        end

        // R9: forwarded clock polarity.
        @(posedge clk); #1;
        chk("R9 clock true, high phase", rclk_o, 1'b1);
        rclk_inv = 1'b1;
        #1;
        chk("R9 clock inverted, high phase", rclk_o, 1'b0);
        @(negedge clk); #1;
        chk("R9 clock inverted, low phase", rclk_o, 1'b1);
        rclk_inv = 1'b0;
        #1;
        chk("R9 clock true, low phase", rclk_o, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule